// File: doc/BRIEF.md
# Branch Outcome and Target Resolver

This block resolves control transfers for an 8-bit microcontroller core. The decoder supplies a branch kind code. It also supplies the program counter, already advanced past the instruction, and two operand bytes. The current accumulator, carry flag, a tested bit value and one working-register value come in alongside. One clock after a valid request, the block reports four things:

- whether the transfer is taken;
- the next program counter;
- the machine-cycle count of the instruction;
- the side effects the sequencer must commit.

The side effects are an updated carry, a decremented register value with its write strobe, and a request to clear the tested bit.

Each jump form uses its own target format:

- **Relative.** The low operand byte is a signed displacement added to the program counter.
- **Page-absolute.** An 11-bit field replaces the low address bits and keeps the current 2 KB page.
- **Long.** Both operand bytes form a full 16-bit address.

The sequencer does not need to decode the kind again to apply these results. Instruction fetch and the stack work for calls and returns are outside this block.

Kind codes on `kind_i`:

| Code | Kind |
|------|------|
| 0 | not a branch |
| 1 | jump if accumulator zero |
| 2 | jump if accumulator non-zero |
| 3 | jump if carry set |
| 4 | jump if carry clear |
| 5 | jump if bit set |
| 6 | jump if bit clear |
| 7 | jump if bit set, then clear the bit |
| 8 | decrement register, jump if the result is non-zero |
| 9 | compare, jump if not equal |
| 10 | short relative jump |
| 11 | page-absolute jump |
| 12 | long jump |
| 13–15 | not a branch |

Top module: `branch_resolver`

## Requirements
- R1: While `rst_i` is high, and on the first clock after it, every output is zero.
- R2: `out_valid_o` is high exactly in the cycle after a cycle with `valid_i` high. The strobes `taken_o`, `reg_we_o` and `bit_clr_o` are low whenever `out_valid_o` is low.
- R3: Kind 1 is taken when `acc_i` is 0x00. Kind 2 is taken when `acc_i` is non-zero.
- R4: Kinds 3 and 4 are taken when `carry_i` is 1 and 0 respectively. Kinds 5 and 6 are taken when `bit_i` is 1 and 0 respectively.
- R5: Kind 7 is taken when `bit_i` is 1. `bit_clr_o` is high only for a taken kind 7 and never for any other kind.
- R6: Kind 8 always outputs `reg_o` = `reg_i` − 1 (mod 256) with `reg_we_o` high. It is taken when that result is non-zero. No other kind raises `reg_we_o`.
- R7: Kind 9 compares `reg_i` (destination) with `op_hi_i` (source) and is taken when they differ. It sets `carry_o` to 1 when `reg_i` < `op_hi_i` (unsigned) and to 0 otherwise. For every other kind, `carry_o` equals `carry_i`.
- R8: For taken kinds 1 to 10, `next_pc_o` is `pc_i` plus the sign-extended `op_lo_i`, modulo 2^16. The reach is −128 to +127.
- R9: Kind 11 is always taken. Its target is {`pc_i`[15:11], `op_hi_i`[2:0], `op_lo_i`}.
- R10: Kind 12 is always taken. Its target is {`op_hi_i`, `op_lo_i`}.
- R11: When a request is not taken, including kinds 0 and 13 to 15, `next_pc_o` equals `pc_i` and `bit_clr_o` is low.
- R12: `cycles_o` is 2 for kinds 1 to 12 and 1 for kinds 0 and 13 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request present this cycle |
| kind_i | input | 4 | Branch kind code |
| pc_i | input | 16 | Program counter after the instruction |
| op_lo_i | input | 8 | Displacement or low address byte |
| op_hi_i | input | 8 | High address byte or compare source |
| acc_i | input | 8 | Accumulator value |
| carry_i | input | 1 | Current carry flag |
| bit_i | input | 1 | Value of the tested bit |
| reg_i | input | 8 | Working-register value (counter or compare destination) |
| out_valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Transfer taken |
| next_pc_o | output | 16 | Next program counter |
| carry_o | output | 1 | Carry value to commit |
| reg_o | output | 8 | Decremented register value |
| reg_we_o | output | 1 | Register write strobe |
| bit_clr_o | output | 1 | Request to clear the tested bit |
| cycles_o | output | 2 | Machine cycles of the instruction |

## Verification
Two pairs of effects land in the same result cycle: the bit-clear request with the redirect of a taken kind 7, and the carry rewrite with the not-equal decision of kind 9. The bench provokes kind 7 with the tested bit both set and clear. It provokes kind 9 with the destination below, equal to and above the source, both in directed cases and in a seeded random stream. Each result is judged field by field against a bench model that computes the taken flag, target, carry and clear request separately. A clear request without a redirect, or a carry left stale beside a correct decision, therefore shows up as its own failure.

// File: rtl/br_pkg.sv
package br_pkg;

  typedef enum logic [3:0] {
    BK_NONE    = 4'd0,
    BK_ACC_Z   = 4'd1,
    BK_ACC_NZ  = 4'd2,
    BK_CY      = 4'd3,
    BK_NCY     = 4'd4,
    BK_BIT     = 4'd5,
    BK_NBIT    = 4'd6,
    BK_BIT_CLR = 4'd7,
    BK_DEC_NZ  = 4'd8,
    BK_CMP_NE  = 4'd9,
    BK_SHORT   = 4'd10,
    BK_PAGE    = 4'd11,
    BK_LONG    = 4'd12
  } br_kind_e;

  typedef enum logic [1:0] {
    TF_REL  = 2'd0,
    TF_PAGE = 2'd1,
    TF_LONG = 2'd2
  } tgt_fmt_e;

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CYC_W   = 2,
  parameter int CYC_BR  = 2,
  parameter int CYC_SEQ = 1
) (
  input  logic [3:0]       kind_i,
  input  logic [DW-1:0]    acc_i,
  input  logic             carry_i,
  input  logic             bit_i,
  input  logic [DW-1:0]    reg_i,
  input  logic [DW-1:0]    src_i,
  output logic             taken_o,
  output logic             carry_o,
  output logic [DW-1:0]    reg_o,
  output logic             reg_we_o,
  output logic             bit_clr_o,
  output tgt_fmt_e         fmt_o,
  output logic [CYC_W-1:0] cycles_o
);

  localparam logic [CYC_W-1:0] CB = CYC_W'(CYC_BR);
  localparam logic [CYC_W-1:0] CS = CYC_W'(CYC_SEQ);

  logic [DW:0]   cmp_diff;
  logic          cmp_borrow;
  logic          cmp_ne;
  logic [DW-1:0] dec_val;
  logic          acc_zero;

  // one subtractor yields both the inequality and the unsigned borrow
  assign cmp_diff   = {1'b0, reg_i} - {1'b0, src_i};
  assign cmp_borrow = cmp_diff[DW];
  assign cmp_ne     = |cmp_diff[DW-1:0];
  assign dec_val    = reg_i - DW'(1);
  assign acc_zero   = (acc_i == '0);

  always_comb begin
    taken_o   = 1'b0;
    carry_o   = carry_i;
    reg_o     = reg_i;
    reg_we_o  = 1'b0;
    bit_clr_o = 1'b0;
    fmt_o     = TF_REL;
    cycles_o  = CB;
    case (kind_i)
      BK_ACC_Z:   taken_o = acc_zero;
      BK_ACC_NZ:  taken_o = !acc_zero;
      BK_CY:      taken_o = carry_i;
      BK_NCY:     taken_o = !carry_i;
      BK_BIT:     taken_o = bit_i;
      BK_NBIT:    taken_o = !bit_i;
      BK_BIT_CLR: begin
        taken_o   = bit_i;
        bit_clr_o = bit_i;
      end
      BK_DEC_NZ: begin
        reg_o    = dec_val;
        reg_we_o = 1'b1;
        taken_o  = |dec_val;
      end
      BK_CMP_NE: begin
        taken_o = cmp_ne;
        carry_o = cmp_borrow;
      end
      BK_SHORT:   taken_o = 1'b1;
      BK_PAGE: begin
        taken_o = 1'b1;
        fmt_o   = TF_PAGE;
      end
      BK_LONG: begin
        taken_o = 1'b1;
        fmt_o   = TF_LONG;
      end
      default:    cycles_o = CS;
    endcase
  end

endmodule

// File: rtl/br_target_gen.sv
module br_target_gen
  import br_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11
) (
  input  tgt_fmt_e          fmt_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DW-1:0]     op_lo_i,
  input  logic [DW-1:0]     op_hi_i,
  output logic [PC_W-1:0]   target_o
);

  localparam int HI_FIELD = PAGE_W - DW;
  localparam int LONG_W   = 2 * DW;

  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] page_tgt;
  logic [PC_W-1:0] long_tgt;

  assign rel_tgt  = pc_i + {{(PC_W-DW){op_lo_i[DW-1]}}, op_lo_i};
  assign page_tgt = {pc_i[PC_W-1:PAGE_W], op_hi_i[HI_FIELD-1:0], op_lo_i};

  generate
    if (PC_W >= LONG_W) begin : g_long_ext
      assign long_tgt = PC_W'({op_hi_i, op_lo_i});
    end else begin : g_long_trunc
      logic [LONG_W-1:0] long_full;
      assign long_full = {op_hi_i, op_lo_i};
      assign long_tgt  = long_full[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    case (fmt_i)
      TF_PAGE: target_o = page_tgt;
      TF_LONG: target_o = long_tgt;
      default: target_o = rel_tgt;
    endcase
  end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PC_W    = 16,
  parameter int PAGE_W  = 11,
  parameter int CYC_W   = 2,
  parameter int CYC_BR  = 2,
  parameter int CYC_SEQ = 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             valid_i,
  input  logic [3:0]       kind_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [DW-1:0]    op_lo_i,
  input  logic [DW-1:0]    op_hi_i,
  input  logic [DW-1:0]    acc_i,
  input  logic             carry_i,
  input  logic             bit_i,
  input  logic [DW-1:0]    reg_i,
  output logic             out_valid_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             carry_o,
  output logic [DW-1:0]    reg_o,
  output logic             reg_we_o,
  output logic             bit_clr_o,
  output logic [CYC_W-1:0] cycles_o
);

  logic             c_taken;
  logic             c_carry;
  logic [DW-1:0]    c_reg;
  logic             c_reg_we;
  logic             c_bit_clr;
  tgt_fmt_e         c_fmt;
  logic [CYC_W-1:0] c_cycles;
  logic [PC_W-1:0]  t_target;
  logic [PC_W-1:0]  pc_nx;

  br_cond_eval #(
    .DW(DW), .CYC_W(CYC_W), .CYC_BR(CYC_BR), .CYC_SEQ(CYC_SEQ)
  ) u_cond (
    .kind_i   (kind_i),
    .acc_i    (acc_i),
    .carry_i  (carry_i),
    .bit_i    (bit_i),
    .reg_i    (reg_i),
    .src_i    (op_hi_i),
    .taken_o  (c_taken),
    .carry_o  (c_carry),
    .reg_o    (c_reg),
    .reg_we_o (c_reg_we),
    .bit_clr_o(c_bit_clr),
    .fmt_o    (c_fmt),
    .cycles_o (c_cycles)
  );

  br_target_gen #(
    .DW(DW), .PC_W(PC_W), .PAGE_W(PAGE_W)
  ) u_tgt (
    .fmt_i   (c_fmt),
    .pc_i    (pc_i),
    .op_lo_i (op_lo_i),
    .op_hi_i (op_hi_i),
    .target_o(t_target)
  );

  assign pc_nx = c_taken ? t_target : pc_i;

  // strobes pulse for one cycle; data fields hold the last result
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      out_valid_o <= 1'b0;
      taken_o     <= 1'b0;
      next_pc_o   <= '0;
      carry_o     <= 1'b0;
      reg_o       <= '0;
      reg_we_o    <= 1'b0;
      bit_clr_o   <= 1'b0;
      cycles_o    <= '0;
    end else begin
      out_valid_o <= valid_i;
      taken_o     <= valid_i & c_taken;
      reg_we_o    <= valid_i & c_reg_we;
      bit_clr_o   <= valid_i & c_bit_clr;
      if (valid_i) begin
        next_pc_o <= pc_nx;
        carry_o   <= c_carry;
        reg_o     <= c_reg;
        cycles_o  <= c_cycles;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |=> out_valid_o); // R2
  AST_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !out_valid_o |-> !(taken_o || reg_we_o || bit_clr_o)); // R2
  AST_CLEAR_NEEDS_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
    bit_clr_o |-> taken_o); // R5
  AST_FALLTHROUGH_PC: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_valid_o && !taken_o) |-> (next_pc_o == $past(pc_i))); // R11
  AST_LONG_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && kind_i == BK_LONG) |=> (taken_o && next_pc_o == $past({op_hi_i, op_lo_i}))); // R10
  AST_CYCLE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    out_valid_o |-> (cycles_o == CYC_W'(CYC_BR) || cycles_o == CYC_W'(CYC_SEQ))); // R12

endmodule

// File: tb/branch_resolver_tb.sv
`timescale 1ns/1ps
module branch_resolver_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid;
  logic [3:0]  kind;
  logic [15:0] pc;
  logic [7:0]  op_lo, op_hi, acc, rg;
  logic        cy, bt;
  logic        o_valid, o_taken, o_carry, o_reg_we, o_bit_clr;
  logic [15:0] o_pc;
  logic [7:0]  o_reg;
  logic [1:0]  o_cycles;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  branch_resolver u_dut (
    .clk_i(clk), .rst_i(rst), .valid_i(valid), .kind_i(kind), .pc_i(pc),
    .op_lo_i(op_lo), .op_hi_i(op_hi), .acc_i(acc), .carry_i(cy), .bit_i(bt),
    .reg_i(rg), .out_valid_o(o_valid), .taken_o(o_taken), .next_pc_o(o_pc),
    .carry_o(o_carry), .reg_o(o_reg), .reg_we_o(o_reg_we),
    .bit_clr_o(o_bit_clr), .cycles_o(o_cycles)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string cond_tag(input logic [3:0] k);
    case (k)
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4, 4'd5, 4'd6: return "R4";
      4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      4'd11: return "R9";
      4'd12: return "R10";
      4'd10: return "R8";
      default: return "R11";
    endcase
  endfunction

  // independent reference of the requirements
  task automatic model(input logic [3:0] k, input logic [15:0] p,
                       input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] a, input logic c, input logic b,
                       input logic [7:0] r,
                       output logic tk, output logic [15:0] npc,
                       output logic ncy, output logic [7:0] nrg,
                       output logic rwe, output logic bclr,
                       output logic [1:0] cyc);
    logic [15:0] tgt;
    tk = 1'b0; ncy = c; nrg = r; rwe = 1'b0; bclr = 1'b0;
    case (k)
      4'd1: tk = (a == 8'h00);
      4'd2: tk = (a != 8'h00);
      4'd3: tk = c;
      4'd4: tk = !c;
      4'd5: tk = b;
      4'd6: tk = !b;
      4'd7: begin tk = b; bclr = b; end
      4'd8: begin nrg = r - 8'd1; rwe = 1'b1; tk = (r != 8'd1); end
      4'd9: begin tk = (r != hi); ncy = (r < hi); end
      4'd10, 4'd11, 4'd12: tk = 1'b1;
      default: ;
    endcase
    if (k == 4'd11)      tgt = {p[15:11], hi[2:0], lo};
    else if (k == 4'd12) tgt = {hi, lo};
    else                 tgt = p + {{8{lo[7]}}, lo};
    npc = tk ? tgt : p;
    cyc = (k >= 4'd1 && k <= 4'd12) ? 2'd2 : 2'd1;
  endtask

  // called at a falling edge; drives, waits one cycle, checks
  task automatic apply(input logic [3:0] k, input logic [15:0] p,
                       input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] a, input logic c, input logic b,
                       input logic [7:0] r);
    logic tk, ncy, rwe, bclr;
    logic [15:0] npc;
    logic [7:0] nrg;
    logic [1:0] cyc;
    string tag;
    model(k, p, lo, hi, a, c, b, r, tk, npc, ncy, nrg, rwe, bclr, cyc);
    valid = 1'b1; kind = k; pc = p; op_lo = lo; op_hi = hi;
    acc = a; cy = c; bt = b; rg = r;
    @(negedge clk);
    valid = 1'b0;
    tag = cond_tag(k);
    check("R2", "out_valid", 32'(o_valid), 32'd1);
    check(tag, "taken", 32'(o_taken), 32'(tk));
    if (!tk) check("R11", "fallthrough pc", 32'(o_pc), 32'(npc));
    else if (k == 4'd11) check("R9", "page target", 32'(o_pc), 32'(npc));
    else if (k == 4'd12) check("R10", "long target", 32'(o_pc), 32'(npc));
    else check("R8", "relative target", 32'(o_pc), 32'(npc));
    check("R7", "carry", 32'(o_carry), 32'(ncy));
    check("R6", "reg write", 32'(o_reg_we), 32'(rwe));
    if (rwe) check("R6", "reg value", 32'(o_reg), 32'(nrg));
    check("R5", "bit clear", 32'(o_bit_clr), 32'(bclr));
    check("R12", "cycles", 32'(o_cycles), 32'(cyc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd90817);
    rst = 1'b1; valid = 1'b0; kind = '0; pc = '0; op_lo = '0; op_hi = '0;
    acc = '0; cy = 1'b0; bt = 1'b0; rg = '0;
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", 32'(o_valid), 32'd0);
    check("R1", "pc in reset", 32'(o_pc), 32'd0);
    check("R1", "strobes in reset", 32'({o_taken, o_reg_we, o_bit_clr}), 32'd0);
    check("R1", "cycles in reset", 32'(o_cycles), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", "idle valid", 32'(o_valid), 32'd0);

    // directed corners
    apply(4'd1, 16'h0100, 8'h10, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00);   // R3 zero acc
    apply(4'd2, 16'h0100, 8'h10, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00);   // R3 not taken
    apply(4'd7, 16'h0200, 8'hF0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00);   // R5 clear with redirect
    apply(4'd7, 16'h0200, 8'hF0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00);   // R5 no clear
    apply(4'd8, 16'h0300, 8'hFE, 8'h00, 8'h00, 1'b1, 1'b0, 8'h01);   // R6 reaches zero
    apply(4'd8, 16'h0300, 8'hFE, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00);   // R6 wraps to FF
    apply(4'd9, 16'h0400, 8'h05, 8'h40, 8'h00, 1'b1, 1'b0, 8'h40);   // R7 equal
    apply(4'd9, 16'h0400, 8'h05, 8'h41, 8'h00, 1'b0, 1'b0, 8'h40);   // R7 below
    apply(4'd9, 16'h0400, 8'h05, 8'h3F, 8'h00, 1'b1, 1'b0, 8'h40);   // R7 above
    apply(4'd10, 16'h0005, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00);  // R8 wrap backward
    apply(4'd10, 16'hFFF0, 8'h7F, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00);  // R8 wrap forward
    apply(4'd11, 16'h0800, 8'hAB, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00);  // R9 page keep
    apply(4'd12, 16'h1234, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00);  // R10
    apply(4'd13, 16'h5555, 8'h01, 8'h01, 8'h00, 1'b1, 1'b1, 8'h01);  // R11 R12 non-branch
    apply(4'd0, 16'hAAAA, 8'h01, 8'h01, 8'h00, 1'b1, 1'b1, 8'h01);   // R11 R12 non-branch
    @(negedge clk);
    check("R2", "strobes idle", 32'({o_valid, o_taken, o_reg_we, o_bit_clr}), 32'd0);

    // seeded random stream with biased corner values
    for (int i = 0; i < 600; i++) begin
      logic [7:0] ra, rr, rh;
      rh = 8'($urandom);
      ra = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      case ($urandom_range(0, 3))
        0: rr = 8'h01;
        1: rr = rh;
        default: rr = 8'($urandom);
      endcase
      apply(4'($urandom_range(0, 15)), 16'($urandom), 8'($urandom), rh, ra,
            1'($urandom), 1'($urandom), rr);
      if ($urandom_range(0, 7) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule